// File: doc/BRIEF.md
# Depth-First Wavelet Block Sequencer

This block produces the issue order that drives a multi-level separable 2-D inverse wavelet synthesis datapath which reconstructs the image one spatial wavelet block at a time. The image of IMG × IMG coefficients is split into square blocks of 2^LEVELS × 2^LEVELS. The sequencer finishes every synthesis level of one block before it moves on to the next block. Temporary low-low results therefore only ever span one block, not a whole subband.

For every issue the block presents a level index, a two-bit phase code and a subband row/column coordinate. The phase code selects either the high/high plus high/low coefficient pair or the low/high plus low/low pair at that coordinate. The block also flags when the low/low operand must come from the datapath's own temporary buffer instead of the external coefficient stream, and it marks the last issue of each block and of the frame. Issues leave on a valid/ready stream. The stream advances only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, every output field holds its value and no issue is lost or duplicated. With `out_ready` held high the stream runs without gaps. A frame starts on a `start` pulse, and `done` pulses once the frame's final issue has been taken.

Top module: `wbs_seq`

## Requirements
- R1: After reset, `out_valid` and `done` are 0, and they stay 0 until `start` is seen.
- R2: A `start` pulse while idle makes `out_valid` high on the following cycle. The first issue is level 1, phase 0, row 0, column 0. A `start` pulse while a frame is running has no effect on the issue stream.
- R3: Blocks are visited in row-major order. With NB = IMG / 2^LEVELS blocks per side, the block column index j advances fastest and the block row index i advances after column NB−1.
- R4: Inside block (i,j), levels run 1, 2, …, LEVELS in ascending order. Level d issues the 4^(d−1) positions (r,s) with 0 ≤ r,s < 2^(d−1): r is the outer loop and s the inner loop. The presented coordinates are row = 2^(d−1)·i + r and column = 2^(d−1)·j + s. `out_level` carries d as an unsigned number.
- R5: Each position is issued twice in a row with the same level and coordinates. The first issue has `out_phase` = 0 (high/high and high/low pair) and the second has `out_phase` = 1 (low/high and low/low pair).
- R6: Level d of a block begins at issue (2/3)(4^(d−1)−1) counted from the block's first issue. A block takes (2/3)(4^LEVELS−1) issues. With `out_ready` held high, issue k of the frame is presented k cycles after the first, and a frame takes IMG²·(2/3)(1−4^−LEVELS) cycles.
- R7: `out_ll_buf` is 1 exactly on phase-1 issues at levels above 1, and 0 on every other issue.
- R8: `out_blk_last` is 1 only on the final issue of each block (level LEVELS, r = s = 2^(LEVELS−1)−1, phase 1). `out_frm_last` is 1 only on the final issue of the last block (i = j = NB−1).
- R9: `done` is high for exactly one cycle, on the cycle after the frame-last issue is accepted, and `out_valid` is 0 in that cycle.
- R10: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with every issue field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a frame when the block is idle |
| out_ready | input | 1 | Downstream accepts the presented issue |
| out_valid | output | 1 | An issue is presented |
| out_level | output | $clog2(LEVELS+1) | Synthesis level d, 1-based |
| out_phase | output | 2 | 0: high/high + high/low pair, 1: low/high + low/low pair |
| out_row | output | $clog2(IMG) | Subband row coordinate |
| out_col | output | $clog2(IMG) | Subband column coordinate |
| out_ll_buf | output | 1 | Take the low/low operand from the temporary buffer |
| out_blk_last | output | 1 | Last issue of the current block |
| out_frm_last | output | 1 | Last issue of the frame |
| done | output | 1 | One-cycle pulse after the frame completes |

## Verification
The assertions assume that reset is applied before the first clock edge and that `out_ready` is an ordinary synchronous input that may fall on any cycle, including mid-pair. They also assume that `start` can arrive at any time and only matters when the block is idle. The stimulus changes `out_ready` and `start` only away from the active edge. It runs frames with `out_ready` held high, with two different irregular back-pressure patterns, and with a `start` pulse injected mid-frame. Every accepted issue is compared against an independently built list, and the data being checked carries the stall and ignore behaviour.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  typedef enum logic [1:0] {
    PH_HIGH = 2'd0,
    PH_LOW  = 2'd1
  } phase_e;
endpackage

// File: rtl/wbs_tree_walk.sv
module wbs_tree_walk
  import wbs_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int LVW    = 2,
  parameter int PW     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           step,
  output logic [LVW-1:0] level,
  output logic [PW-1:0]  pos_r,
  output logic [PW-1:0]  pos_s,
  output phase_e         phase,
  output logic           tree_end
);
  logic [PW-1:0] side_m1;
  logic          at_row_end;
  logic          at_lvl_end;

  always_comb begin
    side_m1    = PW'((32'd1 << (32'(level) - 32'd1)) - 32'd1);
    at_row_end = (pos_s == side_m1);
    at_lvl_end = at_row_end && (pos_r == side_m1) && (phase == PH_LOW);
    tree_end   = at_lvl_end && (level == LVW'(LEVELS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= LVW'(1);
      pos_r <= '0;
      pos_s <= '0;
      phase <= PH_HIGH;
    end else if (clear) begin
      level <= LVW'(1);
      pos_r <= '0;
      pos_s <= '0;
      phase <= PH_HIGH;
    end else if (step) begin
      if (phase == PH_HIGH) begin
        phase <= PH_LOW;
      end else begin
        phase <= PH_HIGH;
        if (!at_row_end) begin
          pos_s <= pos_s + 1'b1;
        end else begin
          pos_s <= '0;
          if (pos_r != side_m1) begin
            pos_r <= pos_r + 1'b1;
          end else begin
            pos_r <= '0;
            level <= (level == LVW'(LEVELS)) ? LVW'(1) : level + 1'b1;
          end
        end
      end
    end
  end

  // R5: the low pair follows the high pair at the same position
  assert_pair_keeps_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == PH_HIGH) |=> (phase == PH_LOW && $stable(pos_r) &&
                                     $stable(pos_s) && $stable(level)));

  // R4: levels only climb by one inside a tree, or wrap at the tree end
  assert_level_climbs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !tree_end) |=> (level == $past(level) || level == $past(level) + 1'b1));

  assert_tree_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && tree_end) |=> (level == LVW'(1) && pos_r == '0 && pos_s == '0));
endmodule

// File: rtl/wbs_block_walk.sv
module wbs_block_walk #(
  parameter int NB = 2,
  parameter int BW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [BW-1:0] blk_i,
  output logic [BW-1:0] blk_j,
  output logic          last_blk
);
  logic col_end;

  always_comb begin
    col_end  = (blk_j == BW'(NB - 1));
    last_blk = col_end && (blk_i == BW'(NB - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_i <= '0;
      blk_j <= '0;
    end else if (clear) begin
      blk_i <= '0;
      blk_j <= '0;
    end else if (step) begin
      if (!col_end) begin
        blk_j <= blk_j + 1'b1;
      end else begin
        blk_j <= '0;
        blk_i <= last_blk ? '0 : blk_i + 1'b1;
      end
    end
  end

  // R3: the column index moves first, the row index stays
  assert_col_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !col_end) |=> (blk_i == $past(blk_i) && blk_j == $past(blk_j) + 1'b1));

  assert_row_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && col_end && !last_blk) |=> (blk_j == '0 && blk_i == $past(blk_i) + 1'b1));
endmodule

// File: rtl/wbs_coord_map.sv
module wbs_coord_map #(
  parameter int LEVELS = 3,
  parameter int LVW    = 2,
  parameter int PW     = 2,
  parameter int BW     = 1,
  parameter int CW     = 4
) (
  input  logic [LVW-1:0] level,
  input  logic [BW-1:0]  blk_i,
  input  logic [BW-1:0]  blk_j,
  input  logic [PW-1:0]  pos_r,
  input  logic [PW-1:0]  pos_s,
  output logic [CW-1:0]  row,
  output logic [CW-1:0]  col
);
  logic [CW-1:0] cand_row [LEVELS];
  logic [CW-1:0] cand_col [LEVELS];

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    assign cand_row[k] = (CW'(blk_i) << k) + CW'(pos_r);
    assign cand_col[k] = (CW'(blk_j) << k) + CW'(pos_s);
  end

  always_comb begin
    row = '0;
    col = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (level == LVW'(k + 1)) begin
        row = cand_row[k];
        col = cand_col[k];
      end
    end
  end
endmodule

// File: rtl/wbs_seq.sv
module wbs_seq
  import wbs_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int IMG    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [$clog2(LEVELS+1)-1:0] out_level,
  output logic [1:0]                 out_phase,
  output logic [$clog2(IMG)-1:0]     out_row,
  output logic [$clog2(IMG)-1:0]     out_col,
  output logic                       out_ll_buf,
  output logic                       out_blk_last,
  output logic                       out_frm_last,
  output logic                       done
);
  localparam int BLK_SIDE = 1 << LEVELS;
  localparam int NB       = IMG / BLK_SIDE;
  localparam int BW       = (NB > 1) ? $clog2(NB) : 1;
  localparam int CW       = $clog2(IMG);
  localparam int LVW      = $clog2(LEVELS + 1);
  localparam int PW       = (LEVELS > 1) ? LEVELS - 1 : 1;
  localparam int LW       = CW + 1;

  logic          busy;
  logic          fire;
  logic          clear;
  logic          tree_end;
  logic          last_blk;
  logic          done_q;
  phase_e        phase;
  logic [PW-1:0] pos_r;
  logic [PW-1:0] pos_s;
  logic [BW-1:0] blk_i;
  logic [BW-1:0] blk_j;

  assign clear = start && !busy;
  assign fire  = busy && out_ready;

  wbs_tree_walk #(.LEVELS(LEVELS), .LVW(LVW), .PW(PW)) u_tree (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(fire),
    .level(out_level), .pos_r(pos_r), .pos_s(pos_s), .phase(phase),
    .tree_end(tree_end)
  );

  wbs_block_walk #(.NB(NB), .BW(BW)) u_blocks (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(fire && tree_end),
    .blk_i(blk_i), .blk_j(blk_j), .last_blk(last_blk)
  );

  wbs_coord_map #(.LEVELS(LEVELS), .LVW(LVW), .PW(PW), .BW(BW), .CW(CW)) u_map (
    .level(out_level), .blk_i(blk_i), .blk_j(blk_j),
    .pos_r(pos_r), .pos_s(pos_s), .row(out_row), .col(out_col)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire && tree_end && last_blk;
      if (clear) begin
        busy <= 1'b1;
      end else if (fire && tree_end && last_blk) begin
        busy <= 1'b0;
      end
    end
  end

  always_comb begin
    out_valid    = busy;
    out_phase    = phase;
    out_ll_buf   = (phase == PH_LOW) && (out_level != LVW'(1));
    out_blk_last = tree_end;
    out_frm_last = tree_end && last_blk;
    done         = done_q;
  end

  logic [LW-1:0] row_lim;
  assign row_lim = LW'(NB) << (out_level - 1'b1);

  // R10: a stalled issue is held unchanged
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_level) && $stable(out_phase) &&
      $stable(out_row) && $stable(out_col) && $stable(out_frm_last)));

  // R9: done follows the accepted frame-last issue and the stream is idle then
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_frm_last) |=> (done && !out_valid));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: coordinates stay inside the level's subband
  assert_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (LW'(out_row) < row_lim && LW'(out_col) < row_lim));

  // R8: a frame-last issue is always a block-last issue
  assert_frm_implies_blk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_frm_last |-> out_blk_last);
endmodule

// File: tb/test_wbs_seq.sv
module test_wbs_seq;
  localparam int PERIOD = 10;
  localparam int LEVELS = 3;
  localparam int IMG    = 16;
  localparam int NB     = IMG / (1 << LEVELS);
  localparam int PER_BLK = 2 * ((4 ** LEVELS) - 1) / 3;
  localparam int TOTAL  = NB * NB * PER_BLK;

  typedef struct {
    int lvl; int ph; int row; int col; int llb; int bl; int fl;
  } iss_t;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic out_ready = 0;
  logic out_valid;
  logic [1:0] out_level;
  logic [1:0] out_phase;
  logic [3:0] out_row;
  logic [3:0] out_col;
  logic out_ll_buf, out_blk_last, out_frm_last, done;

  int total = 0;
  int bad = 0;
  iss_t q[$];

  always #(PERIOD/2) clk = ~clk;

  wbs_seq #(.LEVELS(LEVELS), .IMG(IMG)) i_wbs_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
    .out_valid(out_valid), .out_level(out_level), .out_phase(out_phase),
    .out_row(out_row), .out_col(out_col), .out_ll_buf(out_ll_buf),
    .out_blk_last(out_blk_last), .out_frm_last(out_frm_last), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic build_ref();
    iss_t e;
    q.delete();
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++)
        for (int d = 1; d <= LEVELS; d++) begin
          int side = 1 << (d - 1);
          for (int r = 0; r < side; r++)
            for (int s = 0; s < side; s++)
              for (int p = 0; p < 2; p++) begin
                e.lvl = d; e.ph = p;
                e.row = side * i + r; e.col = side * j + s;
                e.llb = (p == 1 && d > 1) ? 1 : 0;
                e.bl  = (d == LEVELS && r == side - 1 && s == side - 1 && p == 1) ? 1 : 0;
                e.fl  = (e.bl == 1 && i == NB - 1 && j == NB - 1) ? 1 : 0;
                q.push_back(e);
              end
        end
  endtask

  function automatic bit rdy(input int mode, input int cyc);
    if (mode == 0) return 1'b1;
    if (mode == 1) return ((cyc * 7 + 3) % 5) != 0;
    return ((cyc % 4) == 1) || ((cyc % 7) == 3);
  endfunction

  task automatic run_frame(input int mode);
    int cyc = 0;
    int idx = 0;
    bit fin = 0;
    iss_t e;
    build_ref();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(out_valid == 1'b1, "R2 valid after start", int'(out_valid), 1);
    chk(out_level == 2'd1 && out_phase == 2'd0 && out_row == 0 && out_col == 0,
        "R2 first issue", int'(out_row), 0);
    while (!fin && cyc < 5000) begin
      out_ready = rdy(mode, cyc);
      start = (mode == 2 && (cyc == 20 || cyc == 77));
      if (!out_valid) begin
        chk(1'b0, "R10 valid dropped mid-frame", 0, 1);
      end else begin
        e = q[0];
        chk(int'(out_level) == e.lvl && int'(out_row) == e.row && int'(out_col) == e.col,
            "R4 level/coord", int'(out_row) * 16 + int'(out_col), e.row * 16 + e.col);
        chk(int'(out_level) == e.lvl, "R3 level order", int'(out_level), e.lvl);
        chk(int'(out_phase) == e.ph, "R5 phase", int'(out_phase), e.ph);
        chk(int'(out_ll_buf) == e.llb, "R7 ll_buf", int'(out_ll_buf), e.llb);
        chk(int'(out_blk_last) == e.bl && int'(out_frm_last) == e.fl, "R8 last flags",
            int'(out_blk_last) * 2 + int'(out_frm_last), e.bl * 2 + e.fl);
        chk(done == 1'b0, "R9 done while issuing", int'(done), 0);
        if (mode == 0) chk(idx == cyc, "R6 gapless timing", cyc, idx);
        if (out_ready) begin
          void'(q.pop_front());
          idx++;
          if (e.fl == 1) fin = 1;
        end
      end
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk(fin == 1'b1, "R10 frame finished", int'(fin), 1);
    chk(done == 1'b1 && out_valid == 1'b0, "R9 done pulse", int'(done), 1);
    chk(q.size() == 0, "R10 no skipped issue", q.size(), 0);
    chk(idx == TOTAL, "R6 issue count", idx, TOTAL);
    if (mode == 0) chk(cyc == TOTAL, "R6 frame cycles", cyc, TOTAL);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    chk(out_valid == 1'b0, "R1 idle after frame", int'(out_valid), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R1 reset state", int'(out_valid), 0);
    rst_n = 1;
    out_ready = 1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle without start", int'(out_valid), 0);
    run_frame(0);
    run_frame(1);
    run_frame(2);
    run_frame(0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule